// File: doc/BRIEF.md
# Fan Tachometer Capture Timer

This block measures fan speed by timing the gap between tachometer pulses. It has two independent channels. Each channel owns a 16-bit down-counter, a capture register and a timeout limit register. All counters share one 8-bit prescaler that divides the block clock by (prescale + 1). Software loads a channel's counter with 0xFFFF and sets the channel's run bit. The counter then steps down once per prescaler tick. When a synchronized rising edge arrives on the channel's tach input, the counter value is copied into the capture register and the channel stops. If no edge arrives first, the counter reaches the limit value (typically 0xFFFF minus a timeout span such as 0x5000), a timeout is flagged and the channel stops. Software derives the speed from the elapsed count, 0xFFFF minus the capture value. With two pulses per revolution, that count equals clk*60 / ((prescale+1)*rpm*2).

Each channel is driven by a four-state machine. IDLE moves to COUNT when the run bit is set. COUNT moves to CAPTURED on a tach edge, to EXPIRED when the counter equals the limit, and back to IDLE when the run bit is cleared or the counter is written. CAPTURED and EXPIRED move to IDLE when software writes the counter. If the run bit is still set, IDLE then moves on to COUNT.

Six sticky event flags record captures, timeouts and missed edges. Writing ones to the clear address clears them. A 6-bit enable mask decides which flags drive the single interrupt output. Each tach input passes through a two-flop synchronizer before edge detection.

Top module: `tach_timer`

## Requirements
- R1: After reset, both counters and both capture registers read 0xFFFF, both limits read 0, prescale, run, flag and enable registers read 0, and irq is low.
- R2: Register addresses are as follows. Channel A uses 0 (counter), 1 (capture) and 2 (limit). Channel B uses 3, 4 and 5. Address 8 is prescale (8 bits), 9 is run (bit 0 = A, bit 1 = B), 10 is flags (read), 11 is clear (write-one) and 12 is enable. Written values read back at the same address.
- R3: While a channel is in COUNT, its counter decreases by exactly one every (prescale+1) clock cycles.
- R4: A synchronized rising tach edge in COUNT copies the counter into the capture register, sets the capture flag (bit 0 for A, bit 1 for B) and moves to CAPTURED. The counter then holds.
- R5: When the counter equals the limit in COUNT with no edge, the timeout flag is set (bit 4 for A, bit 5 for B) and the channel moves to EXPIRED. The counter holds at the limit and the capture register is unchanged.
- R6: Clearing a channel's run bit stops its counter. The value holds.
- R7: Writing the counter of a halted channel re-arms it. With the run bit set, counting resumes.
- R8: A rising tach edge in CAPTURED or EXPIRED sets the missed-edge flag (bit 2 for A, bit 3 for B).
- R9: Writing to the clear address clears the flags whose bits are 1 and leaves the others. A flag set in the same cycle stays set.
- R10: irq is high exactly when some flag is set whose enable bit is also set.
- R11: Channel B uses only its own run bit, its own input and its own flag bits, and does not disturb channel A.
- R12: A falling tach edge, or a rising edge while a channel is in IDLE, causes no capture and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for addr (combinational) |
| tach_in | input | 2 | Tach inputs, bit 0 channel A, bit 1 channel B |
| irq | output | 1 | Interrupt: OR of enabled flags |

## Verification
The bench times captures against a known number of cycles, with prescale 0 and with prescale 3. A divider that is off by one, or a counter that steps on every clock, falls outside the window. It checks that a halted counter stays frozen and equals the capture value. A channel that kept counting after an edge or a timeout would show a drifting counter. The bench drives edges in IDLE and falling edges during COUNT; a wrong edge detector would raise a capture flag there. It also drives a second edge after a capture, which a design without missed-edge tracking would ignore. It writes clear with zero and with single bits, and it runs channel B alone, so crossed flag positions or shared run bits show up as wrong flag values.

// File: rtl/tach_pkg.sv
package tach_pkg;
    typedef enum logic [1:0] {
        CH_IDLE,
        CH_COUNT,
        CH_CAPTURED,
        CH_EXPIRED
    } ch_state_e;

    // Per-channel register offsets within a channel's address window
    localparam int OFS_CNT    = 0;
    localparam int OFS_CAP    = 1;
    localparam int OFS_LIM    = 2;
    localparam int CH_STRIDE  = 3;
    // Shared registers
    localparam int ADR_PRESC  = 8;
    localparam int ADR_RUN    = 9;
    localparam int ADR_FLAGS  = 10;
    localparam int ADR_CLEAR  = 11;
    localparam int ADR_ENABLE = 12;
endpackage

// File: rtl/tach_sync.sv
module tach_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= din;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign rise = sync_q & ~prev_q;

    // R12: a rise is a single-cycle pulse
    p_rise_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/tach_prescaler.sv
module tach_prescaler #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [PW-1:0] div,
    output logic          tick
);
    logic [PW-1:0] pc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          pc_q <= '0;
        else if (!en)        pc_q <= '0;
        else if (pc_q >= div) pc_q <= '0;
        else                 pc_q <= pc_q + 1'b1;
    end

    assign tick = en && (pc_q >= div);

    // R3: with a nonzero divide value, ticks never come back to back
    p_tick_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div != '0 && en) |=> (!tick || $changed(div)));
endmodule

// File: rtl/tach_channel.sv
module tach_channel
    import tach_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          tick,
    input  logic          rise,
    input  logic          wr_cnt,
    input  logic          wr_cap,
    input  logic          wr_lim,
    input  logic [CW-1:0] wdata,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] cap,
    output logic [CW-1:0] lim,
    output logic          counting,
    output logic          ev_cap,
    output logic          ev_to,
    output logic          ev_miss
);
    ch_state_e st_q, st_d;
    logic [CW-1:0] cnt_q, cap_q, lim_q;
    logic active, at_lim;

    assign active = (st_q == CH_COUNT) && run && !wr_cnt;
    assign at_lim = (cnt_q == lim_q);

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CH_IDLE:     if (run && !wr_cnt) st_d = CH_COUNT;
            CH_COUNT: begin
                if (wr_cnt || !run) st_d = CH_IDLE;
                else if (rise)      st_d = CH_CAPTURED;
                else if (at_lim)    st_d = CH_EXPIRED;
            end
            CH_CAPTURED: if (wr_cnt) st_d = CH_IDLE;
            CH_EXPIRED:  if (wr_cnt) st_d = CH_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CH_IDLE;
        else        st_q <= st_d;
    end

    // datapath outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '1;
            cap_q <= '1;
            lim_q <= '0;
        end else begin
            if (wr_cnt)
                cnt_q <= wdata;
            else if (active && !rise && !at_lim && tick)
                cnt_q <= cnt_q - 1'b1;
            if (active && rise)
                cap_q <= cnt_q;
            else if (wr_cap)
                cap_q <= wdata;
            if (wr_lim)
                lim_q <= wdata;
        end
    end

    assign ev_cap   = active && rise;
    assign ev_to    = active && !rise && at_lim;
    assign ev_miss  = rise && !wr_cnt &&
                      ((st_q == CH_CAPTURED) || (st_q == CH_EXPIRED));
    assign counting = (st_q == CH_COUNT);
    assign cnt = cnt_q;
    assign cap = cap_q;
    assign lim = lim_q;

    p_capture_copies_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ev_cap |=> (cap_q == $past(cnt_q)));
    p_halt_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == CH_CAPTURED || st_q == CH_EXPIRED) && !wr_cnt) |=> $stable(cnt_q));
    p_expire_at_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_to && !wr_lim) |=> (cnt_q == lim_q && st_q == CH_EXPIRED));
    p_single_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_cnt |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - 1'b1));
    p_stop_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_cnt) |=> $stable(cnt_q));
    p_one_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(ev_cap && ev_to));
endmodule

// File: rtl/tach_timer.sv
module tach_timer
    import tach_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int CW     = 16,
    parameter int PW     = 8,
    parameter int AW     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     addr,
    input  logic [CW-1:0]     wdata,
    output logic [CW-1:0]     rdata,
    input  logic [NUM_CH-1:0] tach_in,
    output logic              irq
);
    localparam int FW = 3 * NUM_CH;

    logic [PW-1:0]     presc_q;
    logic [NUM_CH-1:0] run_q;
    logic [FW-1:0]     flags_q, en_q, set_vec, clr_vec;
    logic              tick, any_run;

    logic [CW-1:0]     cnt_v [NUM_CH];
    logic [CW-1:0]     cap_v [NUM_CH];
    logic [CW-1:0]     lim_v [NUM_CH];
    logic [NUM_CH-1:0] cnt_on, ev_cap, ev_to, ev_miss;

    tach_prescaler #(.PW(PW)) u_presc (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (any_run),
        .div  (presc_q),
        .tick (tick)
    );

    assign any_run = |cnt_on;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic rise_c;
        logic sel_cnt, sel_cap, sel_lim;

        assign sel_cnt = wr_en && (addr == AW'(c * CH_STRIDE + OFS_CNT));
        assign sel_cap = wr_en && (addr == AW'(c * CH_STRIDE + OFS_CAP));
        assign sel_lim = wr_en && (addr == AW'(c * CH_STRIDE + OFS_LIM));

        tach_sync u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (tach_in[c]),
            .rise (rise_c)
        );

        tach_channel #(.CW(CW)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .run     (run_q[c]),
            .tick    (tick),
            .rise    (rise_c),
            .wr_cnt  (sel_cnt),
            .wr_cap  (sel_cap),
            .wr_lim  (sel_lim),
            .wdata   (wdata),
            .cnt     (cnt_v[c]),
            .cap     (cap_v[c]),
            .lim     (lim_v[c]),
            .counting(cnt_on[c]),
            .ev_cap  (ev_cap[c]),
            .ev_to   (ev_to[c]),
            .ev_miss (ev_miss[c])
        );
    end

    assign set_vec = {ev_to, ev_miss, ev_cap};
    assign clr_vec = (wr_en && addr == AW'(ADR_CLEAR)) ? wdata[FW-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            presc_q <= '0;
            run_q   <= '0;
            en_q    <= '0;
            flags_q <= '0;
        end else begin
            if (wr_en && addr == AW'(ADR_PRESC))  presc_q <= wdata[PW-1:0];
            if (wr_en && addr == AW'(ADR_RUN))    run_q   <= wdata[NUM_CH-1:0];
            if (wr_en && addr == AW'(ADR_ENABLE)) en_q    <= wdata[FW-1:0];
            flags_q <= (flags_q & ~clr_vec) | set_vec;
        end
    end

    always_comb begin
        rdata = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (addr == AW'(c * CH_STRIDE + OFS_CNT)) rdata = cnt_v[c];
            if (addr == AW'(c * CH_STRIDE + OFS_CAP)) rdata = cap_v[c];
            if (addr == AW'(c * CH_STRIDE + OFS_LIM)) rdata = lim_v[c];
        end
        if (addr == AW'(ADR_PRESC))  rdata = CW'(presc_q);
        if (addr == AW'(ADR_RUN))    rdata = CW'(run_q);
        if (addr == AW'(ADR_FLAGS))  rdata = CW'(flags_q);
        if (addr == AW'(ADR_ENABLE)) rdata = CW'(en_q);
    end

    assign irq = |(flags_q & en_q);

    // R9: a flag stays set until a clear write names it
    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == AW'(ADR_CLEAR)) |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
    // R10: irq needs a pending flag
    p_irq_needs_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flags_q != '0));
    // R5: a timeout event leaves the flag set in the next cycle
    p_timeout_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_to[0]) |=> flags_q[2*NUM_CH]);
endmodule

// File: tb/tach_timer_tb.sv
module tach_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [1:0]  tach_in = '0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [3:0] CNTA = 0, CAPA = 1, LIMA = 2;
    localparam logic [3:0] CNTB = 3, CAPB = 4, LIMB = 5;
    localparam logic [3:0] PRE = 8, RUN = 9, FLG = 10, CLR = 11, ENA = 12;

    always #10 clk = ~clk;

    tach_timer dut_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .rdata  (rdata),
        .tach_in(tach_in),
        .irq    (irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic chk_rng(input string req, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output int v);
        addr = a;
        #1;
        v = int'(rdata);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        int v;
        rd(CNTA, v); chk("R1 counter A", v, 16'hFFFF);
        rd(CAPB, v); chk("R1 capture B", v, 16'hFFFF);
        rd(LIMA, v); chk("R1 limit A", v, 0);
        rd(FLG, v);  chk("R1 flags", v, 0);
        rd(ENA, v);  chk("R1 enable", v, 0);
        chk("R1 irq", int'(irq), 0);
    endtask

    task automatic t_readback();
        int v;
        wr(LIMB, 16'h1234); rd(LIMB, v); chk("R2 limit B readback", v, 16'h1234);
        wr(PRE, 16'h005A);  rd(PRE, v);  chk("R2 prescale readback", v, 16'h5A);
        wr(PRE, 16'h0);
    endtask

    task automatic t_capture_a();
        int c, n, n2;
        wr(LIMA, 16'h0); wr(CNTA, 16'hFFFF); wr(CAPA, 16'hFFFF);
        wr(RUN, 16'h1);
        idle(100);
        tach_in[0] = 1'b1;
        idle(8);
        rd(FLG, n); chk("R4 capture flag A", n, 16'h01);
        rd(CAPA, c); chk_rng("R4 captured elapsed", 16'hFFFF - c, 97, 103);
        rd(CNTA, n); chk("R4 counter equals capture", n, c);
        idle(20);
        rd(CNTA, n2); chk("R4 counter frozen after capture", n2, n);
    endtask

    task automatic t_missed();
        int v;
        tach_in[0] = 1'b0; idle(4);
        tach_in[0] = 1'b1; idle(5);
        rd(FLG, v); chk("R8 missed-edge flag", v, 16'h05);
    endtask

    task automatic t_irq_clear();
        int v;
        chk("R10 irq masked", int'(irq), 0);
        wr(ENA, 16'h01); #1; chk("R10 irq enabled flag", int'(irq), 1);
        wr(CLR, 16'h00); rd(FLG, v); chk("R9 clear with zero", v, 16'h05);
        wr(CLR, 16'h01); rd(FLG, v); chk("R9 clear single bit", v, 16'h04);
        chk("R10 irq after clear", int'(irq), 0);
        wr(CLR, 16'h3F); rd(FLG, v); chk("R9 clear all", v, 0);
        wr(ENA, 16'h00);
    endtask

    task automatic t_reload();
        int v;
        tach_in[0] = 1'b0; idle(4);
        wr(CNTA, 16'hFFFF);
        idle(20);
        rd(CNTA, v); chk_rng("R7 counting after reload", v, 16'hFFFF - 30, 16'hFFFF - 5);
        rd(FLG, v); chk("R7 no flags while counting", v, 0);
    endtask

    task automatic t_stop();
        int a, b;
        wr(RUN, 16'h0);
        rd(CNTA, a); idle(20); rd(CNTA, b);
        chk("R6 counter holds when stopped", b, a);
    endtask

    task automatic t_prescale();
        int c;
        wr(PRE, 16'h3); wr(CNTA, 16'hFFFF); wr(RUN, 16'h1);
        idle(200);
        tach_in[0] = 1'b1; idle(8);
        rd(CAPA, c); chk_rng("R3 divide by four", 16'hFFFF - c, 47, 53);
        tach_in[0] = 1'b0;
        wr(RUN, 16'h0); wr(PRE, 16'h0); wr(CLR, 16'h3F);
    endtask

    task automatic t_timeout();
        int v;
        wr(LIMA, 16'hFFEB); wr(CNTA, 16'hFFFF); wr(CAPA, 16'hFFFF);
        wr(RUN, 16'h1);
        idle(40);
        rd(FLG, v);  chk("R5 timeout flag A", v, 16'h10);
        rd(CNTA, v); chk("R5 counter at limit", v, 16'hFFEB);
        rd(CAPA, v); chk("R5 capture untouched", v, 16'hFFFF);
        wr(ENA, 16'h10); #1; chk("R10 irq on timeout", int'(irq), 1);
        wr(CLR, 16'h10); #1; chk("R10 irq cleared", int'(irq), 0);
        wr(ENA, 16'h0);
    endtask

    task automatic t_falling();
        int v;
        wr(RUN, 16'h0); wr(CNTA, 16'hFFFF); wr(CLR, 16'h3F);
        tach_in[0] = 1'b1; idle(6);
        rd(FLG, v); chk("R12 edge in IDLE ignored", v, 0);
        wr(LIMA, 16'h0); wr(RUN, 16'h1); idle(5);
        tach_in[0] = 1'b0; idle(30);
        rd(FLG, v); chk("R12 falling edge ignored", v, 0);
        rd(CNTA, v); chk_rng("R12 still counting", v, 16'hFFFF - 60, 16'hFFFF - 25);
    endtask

    task automatic t_chan_b();
        int v, a;
        wr(RUN, 16'h0); wr(CLR, 16'h3F);
        rd(CNTA, a);
        wr(LIMB, 16'h0); wr(CNTB, 16'hFFFF); wr(RUN, 16'h2);
        idle(50);
        tach_in[1] = 1'b1; idle(8);
        rd(FLG, v);  chk("R11 capture flag B", v, 16'h02);
        rd(CAPB, v); chk_rng("R11 captured elapsed B", 16'hFFFF - v, 47, 53);
        rd(CNTA, v); chk("R11 channel A undisturbed", v, a);
        wr(RUN, 16'h0); wr(CLR, 16'h3F); wr(CNTB, 16'hFFFF);
        tach_in[1] = 1'b0;
        wr(LIMB, 16'hFFF0); wr(RUN, 16'h2);
        idle(30);
        rd(FLG, v); chk("R11 timeout flag B", v, 16'h20);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_readback();
        t_capture_a();
        t_missed();
        t_irq_clear();
        t_reload();
        t_stop();
        t_prescale();
        t_timeout();
        t_falling();
        t_chan_b();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule